// File: doc/BRIEF.md
# Eight-Lane Data Block Transmitter

This block sends one data block to a card over eight parallel data lines. Bytes arrive on a valid/ready stream. Each byte is split across the lines, one bit per line. Every line is treated as its own serial channel: a start bit, one data bit per byte, a 16-bit checksum computed only over that line's own bits, and an end bit. All eight lines move in lock-step, and one shared output-enable covers the whole packet.

Bit timing comes from an external bit-rate tick. The block passes that tick on to the card as a gated clock enable. If the next byte is needed and the stream has none ready, the block suppresses the enable for that tick. The card then sees no clock edge and no stale bit. A host starts a block by pulsing `start` with the block length. When the release cycle ends the packet, `done` pulses once.

Top module: `wide_blk_tx`

## Requirements
- R1: Out of reset and between blocks, `dat_oe` is 0 and all eight lines of `dat_o` are 1; `busy`, `done` and `in_ready` are 0 while idle.
- R2: The first symbol of a packet is 0 on all eight lines, and `dat_oe` rises to 1 with it.
- R3: Data symbol i (i = 0..N-1, following the start symbol) carries byte i of the stream, with bit k of the byte on line k (line 7 = MSB, line 0 = LSB).
- R4: `blk_len` holds the byte count minus one (0 means 1 byte, 2047 means 2048 bytes). It is captured only in the cycle `start` is accepted, so later changes do not alter the running block.
- R5: After its data, each line sends 16 checksum bits, most significant first. The checksum is CRC-16 with generator x^16+x^12+x^5+1 (0x1021) and an initial value of zero, computed over only the data bits sent on that line.
- R6: After the checksum, one symbol drives 1 on every line with `dat_oe` still 1. The next symbol releases `dat_oe` to 0, with the lines left at 1.
- R7: The outputs `dat_o` and `dat_oe` change only in the cycle after a `card_clk_en` pulse. `card_clk_en` follows `bit_tick`, except that it stays low on a tick where a byte is due and `in_valid` is low.
- R8: A block of N bytes consumes exactly N bytes from the stream, one per data symbol. It spans exactly N+19 `card_clk_en` pulses, counted from the start symbol through the release symbol.
- R9: `done` is a single-cycle pulse. It is high in the same cycle that `dat_oe` first reads 0 after a packet, and at no other time.
- R10: A `start` pulse while `busy` is 1 is ignored. No second packet follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate tick from the card clock divider |
| start | input | 1 | Begin a block (accepted while idle) |
| blk_len | input | 11 | Block length in bytes minus one |
| in_valid | input | 1 | Byte stream: data valid |
| in_data | input | 8 | Byte stream: data |
| in_ready | output | 1 | Byte stream: byte taken this cycle when valid |
| card_clk_en | output | 1 | Gated bit clock enable towards the card |
| dat_o | output | 8 | Card data lines |
| dat_oe | output | 1 | Drive enable for the data lines |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse at packet release |

## Verification
Each symbol becomes visible on `dat_o` and `dat_oe` one clock after the `card_clk_en` pulse that produced it. The bench therefore records the lines in the cycle after each pulse, sampling just after the falling edge. It compares the recorded sequence symbol by symbol against a packet rebuilt from the requirements, including a checksum computed bit by bit in the bench. The block is done on the release symbol itself, so `done` is checked in that same sample, and a separate count catches `done` at any other time. A byte is taken at the rising edge that follows a cycle in which `in_valid` and `in_ready` are both high. The driver decides this after the falling edge, offers one surplus byte, and checks that it is never taken.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_DAT,
    ST_CRC,
    ST_EOB,
    ST_TAIL
  } wbt_state_e;

  // one serial step of the per-lane checksum
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = d ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/wbt_lane.sv
module wbt_lane
  import wbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_sof,
  input  logic ev_dat,
  input  logic ev_crc,
  input  logic ev_eob,
  input  logic din,
  output logic line_o
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_o <= 1'b1;
      crc_q  <= '0;
    end else if (ev_sof) begin
      line_o <= 1'b0;
      crc_q  <= '0;
    end else if (ev_dat) begin
      line_o <= din;
      crc_q  <= crc_step(crc_q, din);
    end else if (ev_crc) begin
      line_o <= crc_q[CRC_W-1];
      crc_q  <= {crc_q[CRC_W-2:0], 1'b0};
    end else if (ev_eob) begin
      line_o <= 1'b1;
    end
  end

  // R7
  lane_ev_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_sof, ev_dat, ev_crc, ev_eob}));

endmodule

// File: rtl/wbt_ctrl.sv
module wbt_ctrl
  import wbt_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             start,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             card_clk_en,
  output logic             ev_sof,
  output logic             ev_dat,
  output logic             ev_crc,
  output logic             ev_eob,
  output logic             oe_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int CCW = $clog2(CRC_W);

  wbt_state_e       state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [CCW-1:0]   crc_cnt_q;
  logic             byte_due, stall, ev_tail;

  assign byte_due    = (state_q == ST_DAT);
  assign stall       = byte_due & ~in_valid;
  assign card_clk_en = bit_tick & ~stall;
  assign in_ready    = byte_due & bit_tick;
  assign ev_sof      = bit_tick & (state_q == ST_SOF);
  assign ev_dat      = in_ready & in_valid;
  assign ev_crc      = bit_tick & (state_q == ST_CRC);
  assign ev_eob      = bit_tick & (state_q == ST_EOB);
  assign ev_tail     = bit_tick & (state_q == ST_TAIL);
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      crc_cnt_q <= '0;
      oe_o      <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          cnt_q   <= blk_len;
          state_q <= ST_SOF;
        end
        ST_SOF: if (ev_sof) begin
          oe_o    <= 1'b1;
          state_q <= ST_DAT;
        end
        ST_DAT: if (ev_dat) begin
          if (cnt_q == '0) begin
            state_q   <= ST_CRC;
            crc_cnt_q <= CCW'(CRC_W - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_CRC: if (ev_crc) begin
          if (crc_cnt_q == '0) state_q <= ST_EOB;
          else crc_cnt_q <= crc_cnt_q - 1'b1;
        end
        ST_EOB: if (ev_eob) state_q <= ST_TAIL;
        ST_TAIL: if (ev_tail) begin
          oe_o    <= 1'b0;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  data_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_CRC) |-> $past(ev_dat));

  // R7
  take_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dat |-> card_clk_en);

endmodule

// File: rtl/wide_blk_tx.sv
module wide_blk_tx
  import wbt_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int MAX_BYTES = 2048,
  parameter int LEN_W     = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             start,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             in_valid,
  input  logic [LANES-1:0] in_data,
  output logic             in_ready,
  output logic             card_clk_en,
  output logic [LANES-1:0] dat_o,
  output logic             dat_oe,
  output logic             busy,
  output logic             done
);

  logic ev_sof, ev_dat, ev_crc, ev_eob;

  wbt_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
    .blk_len(blk_len), .in_valid(in_valid), .in_ready(in_ready),
    .card_clk_en(card_clk_en), .ev_sof(ev_sof), .ev_dat(ev_dat),
    .ev_crc(ev_crc), .ev_eob(ev_eob), .oe_o(dat_oe), .busy_o(busy),
    .done_o(done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wbt_lane u_lane (
      .clk(clk), .rst_n(rst_n), .ev_sof(ev_sof), .ev_dat(ev_dat),
      .ev_crc(ev_crc), .ev_eob(ev_eob), .din(in_data[g]), .line_o(dat_o[g])
    );
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_oe |-> (dat_o == '1));

  // R2
  sof_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> (dat_o == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !card_clk_en |=> ($stable(dat_o) && $stable(dat_oe)));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_oe) |-> done);

endmodule

// File: tb/wide_blk_tx_tb_top.sv
`timescale 1ns/1ps
module wide_blk_tx_tb_top;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bit_tick;
  logic        start = 0;
  logic [10:0] blk_len = '0;
  logic        in_valid = 0;
  logic [7:0]  in_data = '0;
  logic        in_ready, card_clk_en, dat_oe, busy, done;
  logic [7:0]  dat_o;

  int checks = 0, fails = 0;
  int tick_div = 1, tcnt = 0;
  logic [7:0] bytes [0:2100];
  logic [7:0] rec_dat [0:2200];
  logic       rec_oe [0:2200];
  int nrec = 0, frame_cnt = 0, done_bad = 0, idle_bad = 0, consumed = 0;
  logic recording = 0, ce_prev = 0, rel_done = 0;

  always #2.5 clk = ~clk;

  wide_blk_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
    .blk_len(blk_len), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .card_clk_en(card_clk_en), .dat_o(dat_o),
    .dat_oe(dat_oe), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (!rst_n) begin tcnt <= 0; bit_tick <= 1'b0; end
    else if (tcnt >= tick_div - 1) begin tcnt <= 0; bit_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; bit_tick <= 1'b0; end
  end

  // records each symbol in the cycle after its enable pulse
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (done && !(ce_prev && recording && !dat_oe)) done_bad++;
      if (ce_prev) begin
        if (recording || dat_oe) begin
          rec_dat[nrec] = dat_o;
          rec_oe[nrec]  = dat_oe;
          if (nrec < 2200) nrec++;
          recording = 1;
          if (!dat_oe) begin
            recording = 0;
            rel_done  = done;
            frame_cnt++;
          end
        end else if (dat_o !== 8'hFF || dat_oe !== 1'b0) idle_bad++;
      end
      ce_prev = card_clk_en;
    end else ce_prev = 0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [15:0] ref_crc(input int n, input int k);
    logic [15:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic fb;
      fb = bytes[i][k] ^ c[15];
      c = c << 1;
      if (fb) begin c[0] = ~c[0]; c[5] = ~c[5]; c[12] = ~c[12]; end
    end
    return c;
  endfunction

  task automatic run_block(input int n, input int div, input int gap,
                           input int seed, input bit disturb);
    int f0, cyc;
    tick_div = div;
    for (int i = 0; i < n; i++) bytes[i] = 8'(i * 37 + seed * 11 + (i >> 3) * 5 + 3);
    bytes[n] = 8'h5A;
    nrec = 0; consumed = 0; done_bad = 0; idle_bad = 0;
    f0 = frame_cnt; cyc = 0;
    blk_len = 11'(n - 1);
    while (frame_cnt == f0 && cyc < 60000) begin
      @(negedge clk);
      start = (cyc == 0) || (disturb && cyc == 40);
      if (disturb && cyc >= 10) blk_len = 11'd5;
      in_valid = (gap == 0) || (((cyc / gap) % 2) == 0);
      in_data = bytes[consumed];
      #1;
      if (in_valid && in_ready) consumed++;
      cyc++;
    end
    @(negedge clk);
    in_valid = 0; start = 0;
  endtask

  task automatic check_frame(input int n);
    logic [7:0] exp_w;
    logic [15:0] cr [0:7];
    int bad;
    chk(nrec == n + 19, "R8", "enable pulses per block", nrec, n + 19);
    chk(consumed == n, "R8", "bytes consumed", consumed, n);
    chk(rec_dat[0] == 8'h00 && rec_oe[0], "R2", "start symbol", {rec_oe[0], rec_dat[0]}, 9'h100);
    if (nrec != n + 19) return;
    bad = 0;
    for (int i = 0; i < n; i++)
      if (bad == 0 && (rec_dat[1+i] !== bytes[i] || !rec_oe[1+i])) begin
        bad = 1;
        chk(0, "R3", $sformatf("data symbol %0d", i), rec_dat[1+i], bytes[i]);
      end
    if (bad == 0) chk(1, "R3", "data symbols", 0, 0);
    for (int k = 0; k < 8; k++) cr[k] = ref_crc(n, k);
    bad = 0;
    for (int j = 0; j < 16; j++) begin
      for (int k = 0; k < 8; k++) exp_w[k] = cr[k][15-j];
      if (bad == 0 && rec_dat[1+n+j] !== exp_w) begin
        bad = 1;
        chk(0, "R5", $sformatf("crc symbol %0d", j), rec_dat[1+n+j], exp_w);
      end
    end
    if (bad == 0) chk(1, "R5", "crc symbols", 0, 0);
    chk(rec_dat[n+17] == 8'hFF && rec_oe[n+17], "R6", "end symbol",
        {rec_oe[n+17], rec_dat[n+17]}, 9'h1FF);
    chk(!rec_oe[n+18] && rec_dat[n+18] == 8'hFF, "R6", "release symbol",
        {rec_oe[n+18], rec_dat[n+18]}, 9'h0FF);
    chk(rel_done == 1'b1 && done_bad == 0, "R9", "done pulse placement",
        {rel_done, 8'(done_bad)}, 9'h100);
    chk(idle_bad == 0, "R1", "idle lines between blocks", idle_bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(dat_o == 8'hFF && !dat_oe, "R1", "reset lines", {dat_oe, dat_o}, 9'h0FF);
    chk(!busy && !done && !in_ready, "R1", "reset flags", {busy, done, in_ready}, 0);
  endtask

  task automatic t_single();    run_block(1, 1, 0, 1, 0);    check_frame(1);    endtask
  task automatic t_short_div(); run_block(4, 2, 0, 2, 0);    check_frame(4);    endtask
  task automatic t_stall();     run_block(16, 3, 5, 3, 0);   check_frame(16);   endtask

  task automatic t_busy_start();
    run_block(37, 1, 2, 4, 1);
    check_frame(37); // R4: length stays 37 despite blk_len change
    repeat (30) @(negedge clk);
    #1;
    chk(!busy && !dat_oe, "R10", "no packet from start while busy", {busy, dat_oe}, 0);
    blk_len = '0;
  endtask

  task automatic t_max();       run_block(2048, 1, 0, 5, 0); check_frame(2048); endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_short_div();
    t_stall();
    t_busy_start();
    t_max();
    summary();
  end

endmodule